// File: doc/BRIEF.md
# Interrupt Controller Command Register Decoder

This block is the programming front end of an eight-line prioritised interrupt controller. Software reaches it through two byte-wide ports, selected by a single address bit. Writes to these ports are turned into the configuration state and the one-cycle action strobes that an attached priority core consumes. The core keeps the request and in-service registers and picks the winning line. This block keeps the interrupt mask, the rotating priority base, the vector base and the mode flags. It also finds the highest-priority in-service line itself, so that it can carry out non-specific end-of-interrupt commands.

A write to port 0 is one of three kinds, and bits 4 and 3 tell them apart. With bit 4 set it starts an initialisation sequence. With bit 4 clear and bit 3 set it is a read and poll control word. With both clear it is an operation command, encoded in bits 7:5. Writes to port 1 either step through the initialisation words or load the mask. Reads are combinational. In poll mode a read returns the winning line and retires it.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask, the priority base, the vector base, auto-EOI, nested mode, rotate-on-auto-EOI, special-mask, read-select and the poll flag are all zero, and port-1 writes load the mask.
- R2: A port-0 write with bit 4 set clears the mask, the priority base, special-mask and read-select, and pulses init_flush during that write cycle.
- R3: The initialisation write records bit 0 as "mode word follows". When bit 0 is 0, it also clears nested mode and auto-EOI. When bit 0 is 1, both flags are left unchanged.
- R4: After an initialisation write, the first port-1 write sets the vector base to data AND 0xF8. The second port-1 write is consumed. When a mode word is expected, the third port-1 write sets nested mode from bit 4 and auto-EOI from bit 1. No port-1 write changes the mask until the sequence ends.
- R5: Outside initialisation, a port-1 write loads the mask with the data byte.
- R6: A port-0 write with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 = 1 arms poll. Bit 1 = 1 loads read-select from bit 0. Bit 6 = 1 loads special-mask from bit 5. When bit 1 or bit 6 is 0, the matching flag is kept.
- R7: An operation command (bits 4 and 3 both 0) with code bits 7:5 = 0 or 4 sets rotate-on-auto-EOI to bit 7.
- R8: Code 1 pulses isr_clr for the in-service line that comes first in the order base, base+1, …, base+7 (mod 8). If no line is in service, nothing is pulsed.
- R9: Code 5 acts as code 1 and also sets the priority base to the cleared line + 1 (mod 8). With nothing in service the base is kept.
- R10: Code 3 pulses isr_clr for line data[2:0]. Code 7 does the same and also sets the base to data[2:0] + 1 (mod 8).
- R11: Code 6 sets the base to data[2:0] + 1 (mod 8). Code 2 changes no state and pulses nothing.
- R12: Without poll, a port-0 read returns the in-service vector when read-select is 1 and the request vector otherwise. A port-1 read returns the mask.
- R13: With poll armed, a read returns the core's winning line and pulses both isr_clr and irr_clr for that line. If the core has no winner, the read returns 7 and pulses nothing. Any read disarms poll.
- R14: isr_clr and irr_clr stay zero in every cycle without a write or read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Port select (0 or 1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational |
| core_irr | input | LINES | Request vector from the core |
| core_isr | input | LINES | In-service vector from the core |
| core_win_valid | input | 1 | Core has a winning request |
| core_win_line | input | IDX_W | Winning line number |
| mask | output | LINES | Interrupt mask register |
| prio_base | output | IDX_W | Line that currently has top priority |
| vec_base | output | 8 | Vector base |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nested_mode | output | 1 | Special nested mode |
| rot_auto_eoi | output | 1 | Rotate on automatic EOI |
| special_mask | output | 1 | Special mask mode |
| isr_clr | output | LINES | In-service clear pulses |
| irr_clr | output | LINES | Request clear pulses (poll) |
| init_flush | output | 1 | Discard edge requests (init write) |

## Verification
The assertions check these on every cycle:
- the strobe-free quiet of both clear vectors;
- the clearing done by an initialisation write;
- the mask load in normal mode and the vector-base step of the sequence;
- the base set by the set-base command;
- poll disarming on any read.

Other behaviour needs the bench's scenarios. For every base value and every in-service pattern, the bench checks which line a non-specific EOI picks in the rotating order, and where the base moves afterwards. It also checks:
- the full order of the initialisation words, with and without the mode word;
- the gating bits of the control word;
- the poll read against an empty core.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   typedef enum logic [1:0] {
      STEP_NORMAL = 2'd0,
      STEP_VEC    = 2'd1,
      STEP_SKIP   = 2'd2,
      STEP_MODE   = 2'd3
   } init_step_e;

   typedef enum logic [2:0] {
      OP_ROT_OFF    = 3'd0,
      OP_EOI_NS     = 3'd1,
      OP_NOP        = 3'd2,
      OP_EOI_SP     = 3'd3,
      OP_ROT_ON     = 3'd4,
      OP_EOI_NS_ROT = 3'd5,
      OP_SET_BASE   = 3'd6,
      OP_EOI_SP_ROT = 3'd7
   } op_e;

endpackage

// File: rtl/irqd_prio_scan.sv
module irqd_prio_scan #(
   parameter int LINES = 8,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] vec,
   input  logic [IDX_W-1:0] base,
   output logic             hit,
   output logic [IDX_W-1:0] line
);
   logic [LINES-1:0] rot;
   logic [IDX_W-1:0] off;

   for (genvar g = 0; g < LINES; g++) begin : g_rot
      localparam logic [IDX_W-1:0] OFS = IDX_W'(g);
      assign rot[g] = vec[OFS + base];
   end

   always_comb begin
      hit = 1'b0;
      off = '0;
      for (int k = LINES - 1; k >= 0; k--) begin
         if (rot[k]) begin
            hit = 1'b1;
            off = IDX_W'(k);
         end
      end
      line = off + base;
   end
endmodule

// File: rtl/irqd_init_seq.sv
module irqd_init_seq
   import irqd_pkg::*;
#(
   parameter int          LINES     = 8,
   parameter int          IDX_W     = $clog2(LINES),
   parameter logic [7:0]  VEC_RESET = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic       seq_normal,
   output logic [7:0] vec_base,
   output logic       nested_mode,
   output logic       auto_eoi
);
   localparam logic [7:0] VEC_KEEP = 8'hFF << IDX_W;

   init_step_e step_q;
   logic       mode_word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q      <= STEP_NORMAL;
         mode_word_q <= 1'b0;
         vec_base    <= VEC_RESET & VEC_KEEP;
         nested_mode <= 1'b0;
         auto_eoi    <= 1'b0;
      end else if (init_wr) begin
         mode_word_q <= wdata[0];
         step_q      <= STEP_VEC;
         if (!wdata[0]) begin
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
         end
      end else if (data_wr) begin
         case (step_q)
            STEP_VEC: begin
               vec_base <= wdata & VEC_KEEP;
               step_q   <= STEP_SKIP;
            end
            STEP_SKIP: step_q <= mode_word_q ? STEP_MODE : STEP_NORMAL;
            STEP_MODE: begin
               nested_mode <= wdata[4];
               auto_eoi    <= wdata[1];
               step_q      <= STEP_NORMAL;
            end
            default: step_q <= STEP_NORMAL;
         endcase
      end
   end

   assign seq_normal = (step_q == STEP_NORMAL);

   // R4
   vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && step_q == STEP_VEC) |=>
         (vec_base == ($past(wdata) & VEC_KEEP)) && (step_q == STEP_SKIP));

   // R2
   init_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> (step_q == STEP_VEC) && !seq_normal);
endmodule

// File: rtl/irqd_op_decode.sv
module irqd_op_decode
   import irqd_pkg::*;
#(
   parameter int LINES = 8,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             wr0,
   input  logic [7:0]       wdata,
   input  logic             top_hit,
   input  logic [IDX_W-1:0] top_line,
   output logic             is_init,
   output logic [LINES-1:0] eoi_clr,
   output logic             base_ld,
   output logic [IDX_W-1:0] base_new,
   output logic             rot_ld,
   output logic             rot_new,
   output logic             poll_set,
   output logic             rsel_ld,
   output logic             rsel_new,
   output logic             smask_ld,
   output logic             smask_new
);
   logic             is_ctl;
   logic             is_op;
   logic [IDX_W-1:0] wline;
   op_e              op;

   assign is_init = wr0 &  wdata[4];
   assign is_ctl  = wr0 & ~wdata[4] &  wdata[3];
   assign is_op   = wr0 & ~wdata[4] & ~wdata[3];
   assign wline   = wdata[IDX_W-1:0];
   assign op      = op_e'(wdata[7:5]);

   assign poll_set  = is_ctl & wdata[2];
   assign rsel_ld   = is_ctl & wdata[1];
   assign rsel_new  = wdata[0];
   assign smask_ld  = is_ctl & wdata[6];
   assign smask_new = wdata[5];

   always_comb begin
      eoi_clr  = '0;
      base_ld  = 1'b0;
      base_new = '0;
      rot_ld   = 1'b0;
      rot_new  = wdata[7];
      if (is_op) begin
         case (op)
            OP_ROT_OFF, OP_ROT_ON: rot_ld = 1'b1;
            OP_EOI_NS: begin
               if (top_hit) eoi_clr = LINES'(1) << top_line;
            end
            OP_EOI_NS_ROT: begin
               if (top_hit) begin
                  eoi_clr  = LINES'(1) << top_line;
                  base_ld  = 1'b1;
                  base_new = top_line + IDX_W'(1);
               end
            end
            OP_EOI_SP: eoi_clr = LINES'(1) << wline;
            OP_SET_BASE: begin
               base_ld  = 1'b1;
               base_new = wline + IDX_W'(1);
            end
            OP_EOI_SP_ROT: begin
               eoi_clr  = LINES'(1) << wline;
               base_ld  = 1'b1;
               base_new = wline + IDX_W'(1);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
   import irqd_pkg::*;
#(
   parameter int         LINES     = 8,
   parameter int         IDX_W     = $clog2(LINES),
   parameter logic [7:0] VEC_RESET = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [LINES-1:0] core_irr,
   input  logic [LINES-1:0] core_isr,
   input  logic             core_win_valid,
   input  logic [IDX_W-1:0] core_win_line,
   output logic [LINES-1:0] mask,
   output logic [IDX_W-1:0] prio_base,
   output logic [7:0]       vec_base,
   output logic             auto_eoi,
   output logic             nested_mode,
   output logic             rot_auto_eoi,
   output logic             special_mask,
   output logic [LINES-1:0] isr_clr,
   output logic [LINES-1:0] irr_clr,
   output logic             init_flush
);
   localparam logic [7:0] EMPTY_CODE = 8'(LINES - 1);

   if (LINES < 2 || LINES > 8 || LINES != (1 << IDX_W)) begin : g_bad_cfg
      $error("irq_cmd_decoder: LINES must be a power of two in 2..8 with IDX_W = log2(LINES)");
   end

   logic             wr0, wr1;
   logic             seq_normal;
   logic             top_hit;
   logic [IDX_W-1:0] top_line;
   logic             is_init;
   logic [LINES-1:0] eoi_clr;
   logic             base_ld, rot_ld, rot_new, poll_set;
   logic             rsel_ld, rsel_new, smask_ld, smask_new;
   logic [IDX_W-1:0] base_new;
   logic             rsel_q, poll_q;
   logic [LINES-1:0] poll_clr;

   assign wr0 = wr_en & ~addr;
   assign wr1 = wr_en &  addr;

   irqd_prio_scan #(.LINES(LINES), .IDX_W(IDX_W)) u_scan (
      .vec  (core_isr),
      .base (prio_base),
      .hit  (top_hit),
      .line (top_line)
   );

   irqd_op_decode #(.LINES(LINES), .IDX_W(IDX_W)) u_dec (
      .wr0       (wr0),
      .wdata     (wdata),
      .top_hit   (top_hit),
      .top_line  (top_line),
      .is_init   (is_init),
      .eoi_clr   (eoi_clr),
      .base_ld   (base_ld),
      .base_new  (base_new),
      .rot_ld    (rot_ld),
      .rot_new   (rot_new),
      .poll_set  (poll_set),
      .rsel_ld   (rsel_ld),
      .rsel_new  (rsel_new),
      .smask_ld  (smask_ld),
      .smask_new (smask_new)
   );

   irqd_init_seq #(.LINES(LINES), .IDX_W(IDX_W), .VEC_RESET(VEC_RESET)) u_init (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_wr     (is_init),
      .data_wr     (wr1),
      .wdata       (wdata),
      .seq_normal  (seq_normal),
      .vec_base    (vec_base),
      .nested_mode (nested_mode),
      .auto_eoi    (auto_eoi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask         <= '0;
         prio_base    <= '0;
         rsel_q       <= 1'b0;
         special_mask <= 1'b0;
      end else if (is_init) begin
         mask         <= '0;
         prio_base    <= '0;
         rsel_q       <= 1'b0;
         special_mask <= 1'b0;
      end else begin
         if (wr1 && seq_normal) mask <= wdata[LINES-1:0];
         if (base_ld)  prio_base    <= base_new;
         if (rsel_ld)  rsel_q       <= rsel_new;
         if (smask_ld) special_mask <= smask_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_auto_eoi <= 1'b0;
         poll_q       <= 1'b0;
      end else begin
         if (rot_ld) rot_auto_eoi <= rot_new;
         if (poll_set)   poll_q <= 1'b1;
         else if (rd_en) poll_q <= 1'b0;
      end
   end

   assign poll_clr   = (rd_en && poll_q && core_win_valid) ? (LINES'(1) << core_win_line) : '0;
   assign isr_clr    = eoi_clr | poll_clr;
   assign irr_clr    = poll_clr;
   assign init_flush = is_init;

   always_comb begin
      if (poll_q)      rdata = core_win_valid ? 8'(core_win_line) : EMPTY_CODE;
      else if (addr)   rdata = 8'(mask);
      else if (rsel_q) rdata = 8'(core_isr);
      else             rdata = 8'(core_irr);
   end

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && seq_normal) |=> mask == $past(wdata[LINES-1:0]));

   // R2
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4]) |=>
         (mask == '0) && (prio_base == '0) && !special_mask && !rsel_q);

   // R11
   set_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[7:3] == 5'b11000) |=>
         prio_base == $past(wdata[IDX_W-1:0]) + IDX_W'(1));

   // R13
   poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !poll_set) |=> !poll_q);

   // R14
   clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || rd_en) |-> (isr_clr == '0) && (irr_clr == '0));

   // R8
   clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en) |-> $onehot0(isr_clr));
endmodule

// File: tb/irq_cmd_decoder_test.sv
module irq_cmd_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] core_irr = '0, core_isr = '0;
   logic       core_win_valid = 1'b0;
   logic [2:0] core_win_line = '0;
   logic [7:0] mask, vec_base, isr_clr, irr_clr;
   logic [2:0] prio_base;
   logic       auto_eoi, nested_mode, rot_auto_eoi, special_mask, init_flush;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] cap_isr, cap_irr, cap_rd;
   logic       cap_flush;

   always #5 clk = ~clk;

   irq_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .core_irr(core_irr), .core_isr(core_isr),
      .core_win_valid(core_win_valid), .core_win_line(core_win_line),
      .mask(mask), .prio_base(prio_base), .vec_base(vec_base),
      .auto_eoi(auto_eoi), .nested_mode(nested_mode), .rot_auto_eoi(rot_auto_eoi),
      .special_mask(special_mask), .isr_clr(isr_clr), .irr_clr(irr_clr),
      .init_flush(init_flush)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      #1;
      cap_isr = isr_clr; cap_irr = irr_clr; cap_flush = init_flush;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      cap_rd = rdata; cap_isr = isr_clr; cap_irr = irr_clr;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic int first_line(input logic [7:0] v, input int b);
      for (int k = 0; k < 8; k++) if (v[(k + b) % 8]) return (k + b) % 8;
      return -1;
   endfunction

   task automatic set_base(input int b);
      do_wr(1'b0, 8'hC0 | 8'((b + 7) % 8));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", mask, 0);
      chk("R1 base", prio_base, 0);
      chk("R1 vec", vec_base, 0);
      chk("R1 modes", {auto_eoi, nested_mode, rot_auto_eoi, special_mask}, 0);
      core_irr = 8'h3C; core_isr = 8'hC1;
      do_rd(1'b0);
      chk("R1 rsel/poll clear, read irr", cap_rd, 8'h3C);
      do_wr(1'b1, 8'h96);
      chk("R1 normal after reset", mask, 8'h96);

      // R5 + R12 mask sweep
      for (int m = 0; m < 256; m++) begin
         do_wr(1'b1, 8'(m));
         do_rd(1'b1);
         chk("R5 mask load", mask, m);
         chk("R12 port1 read", cap_rd, m);
      end

      // R6 control word
      do_wr(1'b0, 8'h0B);
      do_rd(1'b0);
      chk("R12 isr read", cap_rd, 8'hC1);
      do_wr(1'b0, 8'h08);
      do_rd(1'b0);
      chk("R6 rsel kept when bit1 clear", cap_rd, 8'hC1);
      do_wr(1'b0, 8'h0A);
      do_rd(1'b0);
      chk("R6 rsel cleared", cap_rd, 8'h3C);
      do_wr(1'b0, 8'h68);
      chk("R6 smask set", special_mask, 1);
      do_wr(1'b0, 8'h08);
      chk("R6 smask kept when bit6 clear", special_mask, 1);
      do_wr(1'b0, 8'h48);
      chk("R6 smask cleared", special_mask, 0);

      // R7 rotate on auto EOI
      do_wr(1'b0, 8'h80);
      chk("R7 rot set", rot_auto_eoi, 1);
      do_wr(1'b0, 8'h00);
      chk("R7 rot clear", rot_auto_eoi, 0);
      do_wr(1'b0, 8'h80);

      // R11 set base, code 2 nop
      for (int b = 0; b < 8; b++) begin
         set_base(b);
         chk("R11 set base", prio_base, b);
      end
      core_isr = 8'hFF;
      do_wr(1'b0, 8'h47);
      chk("R11 nop base", prio_base, 7);
      chk("R11 nop clr", cap_isr, 0);
      chk("R11 nop rot", rot_auto_eoi, 1);

      // R8/R9 exhaustive non-specific EOI
      for (int b = 0; b < 8; b++) begin
         for (int p = 0; p < 256; p++) begin
            int ln;
            core_isr = 8'(p);
            ln = first_line(8'(p), b);
            set_base(b);
            do_wr(1'b0, 8'h20);
            chk("R8 ns eoi", cap_isr, (ln < 0) ? 0 : (1 << ln));
            chk("R8 base kept", prio_base, b);
            do_wr(1'b0, 8'hA0);
            chk("R9 ns eoi rot clr", cap_isr, (ln < 0) ? 0 : (1 << ln));
            chk("R9 ns eoi rot base", prio_base, (ln < 0) ? b : (ln + 1) % 8);
         end
      end

      // R10 specific EOI
      core_isr = 8'h00;
      for (int l = 0; l < 8; l++) begin
         set_base(3);
         do_wr(1'b0, 8'h60 | 8'(l));
         chk("R10 sp eoi clr", cap_isr, 1 << l);
         chk("R10 sp eoi base kept", prio_base, 3);
         do_wr(1'b0, 8'hE0 | 8'(l));
         chk("R10 sp eoi rot clr", cap_isr, 1 << l);
         chk("R10 sp eoi rot base", prio_base, (l + 1) % 8);
      end

      // R13 poll
      core_win_valid = 1'b1; core_win_line = 3'd5;
      do_wr(1'b1, 8'h21);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b1);
      chk("R13 poll line", cap_rd, 5);
      chk("R13 poll isr clr", cap_isr, 8'h20);
      chk("R13 poll irr clr", cap_irr, 8'h20);
      do_rd(1'b1);
      chk("R13 poll disarmed", cap_rd, 8'h21);
      chk("R14 plain read no clr", cap_isr | cap_irr, 0);
      core_win_valid = 1'b0;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0);
      chk("R13 poll empty", cap_rd, 7);
      chk("R13 poll empty clr", cap_isr | cap_irr, 0);

      // R2/R3/R4 init with mode word
      do_wr(1'b1, 8'h5A);
      set_base(4);
      do_wr(1'b0, 8'h6B);
      do_wr(1'b0, 8'h11);
      chk("R2 flush pulse", cap_flush, 1);
      chk("R2 mask clr", mask, 0);
      chk("R2 base clr", prio_base, 0);
      chk("R2 smask clr", special_mask, 0);
      do_rd(1'b0);
      chk("R2 rsel clr", cap_rd, 8'h3C);
      do_wr(1'b1, 8'h47);
      chk("R4 vec base", vec_base, 8'h40);
      chk("R4 mask untouched", mask, 0);
      do_wr(1'b1, 8'hFF);
      chk("R4 step2 mask untouched", mask, 0);
      do_wr(1'b1, 8'h12);
      chk("R4 mode word", {nested_mode, auto_eoi}, 2'b11);
      chk("R4 mode word mask untouched", mask, 0);
      do_wr(1'b1, 8'h33);
      chk("R4 back to normal", mask, 8'h33);
      do_wr(1'b0, 8'h11);
      chk("R3 flags kept with mode word", {nested_mode, auto_eoi}, 2'b11);
      do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h10);
      chk("R4 nested only", {nested_mode, auto_eoi}, 2'b10);

      // R3 init without mode word
      do_wr(1'b0, 8'h10);
      chk("R3 flags cleared", {nested_mode, auto_eoi}, 2'b00);
      do_wr(1'b1, 8'h8D);
      chk("R4 vec base 2", vec_base, 8'h88);
      do_wr(1'b1, 8'h55);
      chk("R4 step2 only", mask, 0);
      do_wr(1'b1, 8'h0F);
      chk("R4 normal after two words", mask, 8'h0F);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule